// File: doc/BRIEF.md
# Instruction Fetch Front End with Execute/Decode Stall Handshake

This block is the first stage of a three-stage fetch, decode and execute pipeline. Each time it fetches, it reads four consecutive bytes of program memory starting at the program counter. It packs them into a 32-bit instruction word and presents that word, the address it came from and a valid flag to the decode stage. The program counter then moves on by four. The program memory sits inside the block as four byte-wide banks, so a fetch may start at any byte address, aligned or not. The memory is loaded through a plain byte write port.

Fetching is gated by the later stages. A wait request from execute drops the valid flag and puts the stage into a sticky waiting state. That state ends only when execute reports it is done. Independently of that state, the stage holds everything in place in any cycle where decode has not reported done. Execute can also redirect the program counter to a new byte address. A redirect overrides the normal step of four.

Top module: `instr_fetch_front`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `instr_valid` is 0, `pc_o` equals `RESET_PC` and the stage is not waiting.
- R2: A fetch at address A yields `instr_word` = {mem[A], mem[A+1], mem[A+2], mem[A+3]}. The byte at A lands in bits 31:24 and the byte at A+3 in bits 7:0. Addresses wrap modulo 2^ADDR_W, and A need not be a multiple of four.
- R3: A fetch happens in a cycle where `wait_req` is 0, `dec_done` is 1, and either the stage is not waiting or `exec_done` is 1. After the clock edge of that cycle, `instr_valid` is 1 and `instr_addr` holds the PC the fetch used.
- R4: After a fetch with no redirect, `pc_o` is the old PC plus 4, wrapping modulo 2^ADDR_W.
- R5: When `redir_valid` is 1, `pc_o` takes `redir_addr` at the next edge in any cycle. This overrides the step of four.
- R6: When `wait_req` is 1, no fetch happens that cycle, `instr_valid` is 0 after the edge, and the stage enters the waiting state.
- R7: While the stage is waiting, `exec_done` is 0 and `wait_req` is 0, no fetch happens. `instr_valid`, `instr_addr`, `instr_word` and `pc_o` hold their values, apart from a redirect.
- R8: When the stage is waiting, `exec_done` is 1 and `wait_req` is 0, the waiting state clears. A fetch happens in that same cycle if `dec_done` is 1.
- R9: When `dec_done` is 0, no fetch happens and the decode-side outputs hold their values, even if the stage is not waiting.
- R10: `wait_req` takes precedence over `exec_done` and `dec_done`. With all three at 1, the stage still waits and does not fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_wr_en | input | 1 | Program memory byte write enable |
| mem_wr_addr | input | ADDR_W | Byte address for the write |
| mem_wr_data | input | 8 | Byte to write |
| wait_req | input | 1 | Execute asks fetch to stop and invalidate its output |
| exec_done | input | 1 | Execute has finished its current instruction |
| dec_done | input | 1 | Decode has accepted its input and can take another |
| redir_valid | input | 1 | Execute loads the program counter with a new value |
| redir_addr | input | ADDR_W | New program counter value |
| instr_valid | output | 1 | The instruction word for decode is valid |
| instr_addr | output | ADDR_W | Byte address the instruction word was read from |
| instr_word | output | 32 | Big-endian instruction word |
| pc_o | output | ADDR_W | Current program counter |

## Verification
Every cycle, the bound checker enforces the cycle rules for invalidation on a wait request, holding while waiting or while decode is busy, release on execute done, the PC step and redirect, and the reset state. The byte content and ordering of `instr_word` cannot be checked that way. The same is true of unaligned and wrapping fetches and of long interleavings of wait, release and decode stalls. Those are shown only by the bench, which compares against a byte-level memory model and a model of the stall state, under directed corners and seeded random handshakes.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int LSEL_W = $clog2(LANES);

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fetch_stall_ctl.sv
module fetch_stall_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wait_req,
  input  logic exec_done,
  input  logic dec_done,
  output logic fire,
  output logic wait_q
);
  logic release_ok;

  // execute-done lets a waiting stage go in the same cycle
  assign release_ok = !wait_q || exec_done;
  assign fire       = !wait_req && release_ok && dec_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= 1'b0;
    end else if (wait_req) begin
      wait_q <= 1'b1;
    end else if (wait_q && exec_done) begin
      wait_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fetch_mem_banks.sv
module fetch_mem_banks
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  lane_t             wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rd_word
);
  localparam int IDX_W = ADDR_W - LSEL_W;
  localparam int DEPTH = 1 << IDX_W;

  lane_t             lane_q [LANES];
  logic [LSEL_W-1:0] rot_q;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    lane_t             store [DEPTH];
    logic [LSEL_W-1:0] off;
    logic [ADDR_W-1:0] byte_a;

    // bank b holds the bytes whose address has low bits equal to b
    assign off    = LSEL_W'(b) - rd_addr[LSEL_W-1:0];
    assign byte_a = rd_addr + ADDR_W'(off);

    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr[LSEL_W-1:0] == LSEL_W'(b))) begin
        store[wr_addr[ADDR_W-1:LSEL_W]] <= wr_data;
      end
      if (rd_en) begin
        lane_q[b] <= store[byte_a[ADDR_W-1:LSEL_W]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rot_q <= rd_addr[LSEL_W-1:0];
    end
  end

  // lowest address goes to the most significant lane
  always_comb begin
    rd_word = '0;
    for (int k = 0; k < LANES; k++) begin
      rd_word[WORD_W-1-k*LANE_W -: LANE_W] = lane_q[rot_q + LSEL_W'(k)];
    end
  end
endmodule

// File: rtl/instr_fetch_front.sv
module instr_fetch_front
  import fetch_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter int unsigned RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_wr_en,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  input  logic [7:0]        mem_wr_data,
  input  logic              wait_req,
  input  logic              exec_done,
  input  logic              dec_done,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  output logic              instr_valid,
  output logic [ADDR_W-1:0] instr_addr,
  output logic [31:0]       instr_word,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(LANES);

  logic  fire;
  logic  wait_q;
  word_t bank_word;

  fetch_stall_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wait_req  (wait_req),
    .exec_done (exec_done),
    .dec_done  (dec_done),
    .fire      (fire),
    .wait_q    (wait_q)
  );

  fetch_mem_banks #(.ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .wr_en   (mem_wr_en),
    .wr_addr (mem_wr_addr),
    .wr_data (mem_wr_data),
    .rd_en   (fire && !rst),
    .rd_addr (pc_o),
    .rd_word (bank_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o <= PC_INIT;
    end else if (redir_valid) begin
      pc_o <= redir_addr;
    end else if (fire) begin
      pc_o <= pc_o + PC_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_valid <= 1'b0;
      instr_addr  <= '0;
    end else if (wait_req) begin
      instr_valid <= 1'b0;
    end else if (fire) begin
      instr_valid <= 1'b1;
      instr_addr  <= pc_o;
    end
  end

  assign instr_word = bank_word;
endmodule

// File: rtl/instr_fetch_front_chk.sv
module instr_fetch_front_chk #(
  parameter int          ADDR_W   = 10,
  parameter int unsigned RESET_PC = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              wait_req,
  input logic              exec_done,
  input logic              dec_done,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic              instr_valid,
  input logic [ADDR_W-1:0] instr_addr,
  input logic [31:0]       instr_word,
  input logic [ADDR_W-1:0] pc_o,
  input logic              wait_q,
  input logic              fire
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!instr_valid && !wait_q && pc_o == ADDR_W'(RESET_PC)));

  a_r3_fetch_marks_valid: assert property (@(posedge clk) disable iff (rst)
    fire |=> (instr_valid && instr_addr == $past(pc_o)));

  a_r4_pc_steps: assert property (@(posedge clk) disable iff (rst)
    (fire && !redir_valid) |=> (pc_o == ADDR_W'($past(pc_o) + ADDR_W'(4))));

  a_r5_redirect_wins: assert property (@(posedge clk) disable iff (rst)
    redir_valid |=> (pc_o == $past(redir_addr)));

  a_r6_wait_invalidates: assert property (@(posedge clk) disable iff (rst)
    wait_req |=> (!instr_valid && wait_q));

  a_r7_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !exec_done && !wait_req) |=>
      ($stable(instr_valid) && $stable(instr_addr) && $stable(instr_word)));

  a_r8_release_fetches: assert property (@(posedge clk) disable iff (rst)
    (wait_q && exec_done && dec_done && !wait_req) |=> (instr_valid && !wait_q));

  a_r9_hold_on_decode_busy: assert property (@(posedge clk) disable iff (rst)
    (!wait_req && !dec_done) |=>
      ($stable(instr_valid) && $stable(instr_addr) && $stable(instr_word)));

  a_r10_wait_has_priority: assert property (@(posedge clk) disable iff (rst)
    wait_req |-> !fire);
endmodule

bind instr_fetch_front instr_fetch_front_chk #(
  .ADDR_W   (ADDR_W),
  .RESET_PC (RESET_PC)
) chk_i (.*);

// File: tb/instr_fetch_front_tb_top.sv
module instr_fetch_front_tb_top;
  localparam int          ADDR_W   = 10;
  localparam int unsigned RESET_PC = 8;
  localparam int          MSIZE    = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mem_wr_en = 1'b0;
  logic [ADDR_W-1:0] mem_wr_addr = '0;
  logic [7:0]        mem_wr_data = '0;
  logic              wait_req = 1'b0;
  logic              exec_done = 1'b0;
  logic              dec_done = 1'b0;
  logic              redir_valid = 1'b0;
  logic [ADDR_W-1:0] redir_addr = '0;
  logic              instr_valid;
  logic [ADDR_W-1:0] instr_addr;
  logic [31:0]       instr_word;
  logic [ADDR_W-1:0] pc_o;

  always #5 clk = ~clk;

  instr_fetch_front #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) dut_i (.*);

  logic [7:0]        mdl_mem [MSIZE];
  logic [ADDR_W-1:0] m_pc;
  logic              m_wait;
  logic              m_valid;
  logic [ADDR_W-1:0] m_addr;
  logic [31:0]       m_word;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] a);
    return {mdl_mem[a], mdl_mem[ADDR_W'(a + 1)],
            mdl_mem[ADDR_W'(a + 2)], mdl_mem[ADDR_W'(a + 3)]};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "instr_valid", 32'(instr_valid), 32'(m_valid));
    chk(tag, "pc_o", 32'(pc_o), 32'(m_pc));
    if (m_valid) begin
      chk(tag, "instr_addr", 32'(instr_addr), 32'(m_addr));
      chk(tag, "instr_word", instr_word, m_word);
    end
  endtask

  // inputs already driven; advance one clock and compare with the model
  task automatic cycle(input string tag);
    logic f;
    f = !wait_req && (!m_wait || exec_done) && dec_done;
    if (wait_req) m_valid = 1'b0;
    else if (f) begin
      m_valid = 1'b1;
      m_addr  = m_pc;
      m_word  = exp_word(m_pc);
    end
    if (wait_req) m_wait = 1'b1;
    else if (m_wait && exec_done) m_wait = 1'b0;
    if (redir_valid) m_pc = redir_addr;
    else if (f) m_pc = ADDR_W'(m_pc + 4);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drive(input logic wr, input logic ed, input logic dd,
                       input logic rv, input logic [ADDR_W-1:0] ra);
    wait_req = wr; exec_done = ed; dec_done = dd;
    redir_valid = rv; redir_addr = ra;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // load program memory while reset is held
    for (int i = 0; i < MSIZE; i++) begin
      @(negedge clk);
      mem_wr_en   = 1'b1;
      mem_wr_addr = ADDR_W'(i);
      mem_wr_data = 8'($urandom);
      mdl_mem[i]  = mem_wr_data;
    end
    @(negedge clk);
    mem_wr_en = 1'b0;
    @(negedge clk);
    m_pc = ADDR_W'(RESET_PC); m_wait = 1'b0; m_valid = 1'b0;
    m_addr = '0; m_word = '0;
    compare("R1");
    drive(1'b0, 1'b1, 1'b1, 1'b0, '0);
    rst = 1'b0;
    @(negedge clk);
    m_valid = 1'b0;
    m_pc = ADDR_W'(RESET_PC + 4); m_addr = ADDR_W'(RESET_PC);
    m_valid = 1'b1; m_word = exp_word(ADDR_W'(RESET_PC));
    compare("R1");
    cycle("R2");
    cycle("R3");
    cycle("R4");
    // wait request, hold, then release
    drive(1'b1, 1'b0, 1'b1, 1'b0, '0); cycle("R6");
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0); cycle("R7"); cycle("R7"); cycle("R7");
    drive(1'b0, 1'b1, 1'b1, 1'b0, '0); cycle("R8");
    drive(1'b1, 1'b1, 1'b1, 1'b0, '0); cycle("R10");
    // release seen while decode busy: no fetch, outputs held
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0); cycle("R9"); cycle("R9");
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0); cycle("R9");
    // unaligned redirect near top of memory, then wrapping fetch
    drive(1'b0, 1'b1, 1'b1, 1'b1, ADDR_W'(MSIZE - 2)); cycle("R5");
    drive(1'b0, 1'b1, 1'b1, 1'b0, '0); cycle("R2"); cycle("R4");
    drive(1'b0, 1'b1, 1'b0, 1'b1, ADDR_W'(13)); cycle("R5");
    drive(1'b0, 1'b1, 1'b1, 1'b0, '0); cycle("R2");
    // seeded random handshakes
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom % 8) == 0, ($urandom % 2) == 0, ($urandom % 4) != 0,
            ($urandom % 10) == 0, ADDR_W'($urandom));
      cycle("RND");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule